// File: doc/BRIEF.md
# Masked Vector Compress and Expand Unit

This unit moves vector elements under a per-element mask. In compress mode it walks the source vector, picks every element whose mask bit is set and writes those elements back to back into the destination, beginning at slot 0. It also reports how many elements it packed, which is the number of set mask bits within the active length. Software can use that count as the vector length for later work that should run only on the active elements.

In expand mode the unit does the reverse. Source slot 0, 1, 2 and so on are taken in order and dropped into the destination positions whose mask bit is set. Every other destination position keeps the value it was given when the operation began.

The unit examines one element per clock. A start request captures the source, the mask, the active length, the mode and the prior destination contents. The unit then stays busy for exactly the active length and raises done for one cycle. Element arrays travel as flat buses: element i sits at bits [i*DATA_W +: DATA_W].

Top module: `vec_pack_unit`

## Requirements
- R1: After reset, busy and done are 0, count is 0 and every destination element is 0.
- R2: With op_expand=0 (compress), the source elements whose mask bit is set, among positions below the active length, appear in ascending source order in destination slots 0, 1, 2, and so on.
- R3: When done is high, count equals the number of set mask bits below the active length. During an operation, count rises by at most 1 per cycle and never exceeds the number of elements examined.
- R4: With op_expand=1 (expand), the k-th set mask bit below the active length receives source element k (counting from 0).
- R5: On a start that is accepted, the destination is loaded from init_flat. Any destination element that the operation does not write keeps that value: in compress these are the slots at or above count, and in expand these are the positions whose mask bit is clear or that lie at or above the active length. The destination then holds until the next accepted start.
- R6: start is accepted on a clock edge where busy is low, including the cycle in which done is high. After an accepted start with active length L, busy is high for exactly L cycles and done is high for the single cycle that follows. With L=0, busy never rises and done is high in the cycle right after the start.
- R7: start while busy is high is ignored. The operation in progress continues on the values captured at its own start, and no new capture takes place.
- R8: The active length is vlen, clamped to NUM_ELEM. Mask bits at or above the active length have no effect.
- R9: An all-zero mask gives count 0, and the destination equals init_flat at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op_expand | input | 1 | 0 selects compress, 1 selects expand |
| vlen | input | LEN_W | Requested active length |
| mask | input | NUM_ELEM | One bit per element, 1 means active |
| src_flat | input | NUM_ELEM*DATA_W | Source elements |
| init_flat | input | NUM_ELEM*DATA_W | Prior destination contents |
| busy | output | 1 | High while elements are being examined |
| done | output | 1 | One-cycle completion pulse |
| count | output | LEN_W | Packed length (elements moved so far) |
| dst_flat | output | NUM_ELEM*DATA_W | Destination elements |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next start. The bench provokes this by driving a new start in the very cycle it first sees done. The behavioural reference model then has to agree with the design on busy, done, count and every destination element in each cycle that follows, and the cycle count of the new operation must equal its own length. The other overlap is a start held high while busy, with different data on the inputs. That case is judged by requiring that the final result matches the first operation's inputs alone.

// File: rtl/vec_pack_unit.sv
module vec_pack_unit #(
  parameter int NUM_ELEM = 64,
  parameter int DATA_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         op_expand,
  input  logic [$clog2(NUM_ELEM+1)-1:0] vlen,
  input  logic [NUM_ELEM-1:0]          mask,
  input  logic [NUM_ELEM*DATA_W-1:0]   src_flat,
  input  logic [NUM_ELEM*DATA_W-1:0]   init_flat,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(NUM_ELEM+1)-1:0] count,
  output logic [NUM_ELEM*DATA_W-1:0]   dst_flat
);
  localparam int LEN_W = $clog2(NUM_ELEM + 1);
  localparam int IDX_W = $clog2(NUM_ELEM);

  logic [DATA_W-1:0]   src_q [NUM_ELEM];
  logic [DATA_W-1:0]   dst_q [NUM_ELEM];
  logic [NUM_ELEM-1:0] mask_q;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    idx;
  logic [LEN_W-1:0]    ptr;
  logic                mode_q;
  logic                busy_q;
  logic                done_q;

  wire [LEN_W-1:0] eff_len = (vlen > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vlen;
  wire             accept  = start && !busy_q;
  wire             cur_on  = mask_q[idx[IDX_W-1:0]];
  wire             last    = (idx == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      mask_q <= '0;
      len_q  <= '0;
      idx    <= '0;
      ptr    <= '0;
      for (int i = 0; i < NUM_ELEM; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cur_on) begin
          if (mode_q) dst_q[idx[IDX_W-1:0]] <= src_q[ptr[IDX_W-1:0]];
          else        dst_q[ptr[IDX_W-1:0]] <= src_q[idx[IDX_W-1:0]];
          ptr <= ptr + 1'b1;
        end
        idx <= idx + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (accept) begin
        mode_q <= op_expand;
        mask_q <= mask;
        len_q  <= eff_len;
        idx    <= '0;
        ptr    <= '0;
        busy_q <= (eff_len != '0);
        done_q <= (eff_len == '0);
        for (int i = 0; i < NUM_ELEM; i++) begin
          src_q[i] <= src_flat[i*DATA_W +: DATA_W];
          dst_q[i] <= init_flat[i*DATA_W +: DATA_W];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_out
    assign dst_flat[g*DATA_W +: DATA_W] = dst_q[g];
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign count = ptr;
endmodule

// File: rtl/vec_pack_checker.sv
module vec_pack_checker #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] count,
  input logic [LEN_W-1:0] len_q,
  input logic [LEN_W-1:0] idx
);
  a_r6_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r6_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= idx);
endmodule

bind vec_pack_unit vec_pack_checker #(.LEN_W(LEN_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .count (count),
  .len_q (len_q),
  .idx   (idx)
);

// File: tb/test_vec_pack_unit.sv
module test_vec_pack_unit;
  localparam int NE = 64;
  localparam int DW = 16;
  localparam int LW = $clog2(NE + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_expand = 1'b0;
  logic [LW-1:0] vlen = '0;
  logic [NE-1:0] mask = '0;
  logic [NE*DW-1:0] src_flat = '0;
  logic [NE*DW-1:0] init_flat = '0;
  logic          busy, done;
  logic [LW-1:0] count;
  logic [NE*DW-1:0] dst_flat;

  int total = 0;
  int bad = 0;

  vec_pack_unit #(.NUM_ELEM(NE), .DATA_W(DW)) i_vec_pack_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_expand(op_expand),
    .vlen(vlen), .mask(mask), .src_flat(src_flat), .init_flat(init_flat),
    .busy(busy), .done(done), .count(count), .dst_flat(dst_flat)
  );

  always #5 clk = ~clk;

  // behavioural reference, stepped on every rising edge
  logic          m_busy = 0, m_done = 0, m_mode = 0;
  int            m_len = 0, m_idx = 0, m_cnt = 0;
  logic [NE-1:0] m_mask = '0;
  logic [DW-1:0] m_src [NE];
  logic [DW-1:0] m_dst [NE];
  logic [DW-1:0] m_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_idx = 0;
      for (int i = 0; i < NE; i++) m_dst[i] = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_mask[m_idx]) begin
          if (m_mode) m_dst[m_idx] = m_q.pop_front();
          else        m_dst[m_cnt] = m_src[m_idx];
          m_cnt++;
        end
        m_idx++;
        if (m_idx == m_len) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        m_mode = op_expand;
        m_mask = mask;
        m_len  = (int'(vlen) > NE) ? NE : int'(vlen);
        m_idx = 0; m_cnt = 0;
        m_q.delete();
        for (int i = 0; i < NE; i++) begin
          m_src[i] = src_flat[i*DW +: DW];
          m_dst[i] = init_flat[i*DW +: DW];
          m_q.push_back(src_flat[i*DW +: DW]);
        end
        m_busy = (m_len != 0);
        m_done = (m_len == 0);
      end
    end
  end

  function automatic logic [NE*DW-1:0] model_flat();
    logic [NE*DW-1:0] f;
    for (int i = 0; i < NE; i++) f[i*DW +: DW] = m_dst[i];
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == m_busy, "R6", "busy per cycle", busy, m_busy);
      check(done == m_done, "R6", "done per cycle", done, m_done);
      check(int'(count) == m_cnt, "R3", "count per cycle", count, m_cnt);
      check(dst_flat == model_flat(), "R2 R4 R5", "dst per cycle",
            dst_flat[63:0], model_flat() >> 0);
    end
  end

  // spec-level final result, computed without stepping
  task automatic run_op(input bit ex, input int vl, input logic [NE-1:0] mk,
                        input logic [NE*DW-1:0] s, input logic [NE*DW-1:0] in_v,
                        input string req);
    logic [NE*DW-1:0] e;
    int k = 0, L, n = 0;
    L = (vl > NE) ? NE : vl;
    e = in_v;
    for (int i = 0; i < L; i++) if (mk[i]) begin
      if (ex) e[i*DW +: DW] = s[k*DW +: DW];
      else    e[k*DW +: DW] = s[i*DW +: DW];
      k++;
    end
    start = 1; op_expand = ex; vlen = LW'(vl); mask = mk; src_flat = s; init_flat = in_v;
    do begin
      @(negedge clk);
      start = 0;
      n++;
    end while (!done && n < 200);
    check(n == L + 1, "R6", {req, " cycles to done"}, n, L + 1);
    check(int'(count) == k, "R3", {req, " packed length"}, count, k);
    check(dst_flat == e, req, "final dst", dst_flat[63:0], e[63:0]);
  endtask

  function automatic logic [NE*DW-1:0] rnd_vec();
    logic [NE*DW-1:0] v;
    for (int i = 0; i < NE; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NE*DW-1:0] s, iv, s2;
    logic [NE-1:0] mk;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && count == 0 && dst_flat == '0, "R1",
          "reset state", {busy, done, count}, 0);
    rst_n = 1;
    @(negedge clk);

    s = rnd_vec(); iv = rnd_vec();
    run_op(0, 64, {32{2'b10}}, s, iv, "R2");
    run_op(1, 64, {32{2'b10}}, s, iv, "R4");
    run_op(0, 37, 64'hF0F0_0F0F_1234_8001, rnd_vec(), rnd_vec(), "R2 R5");
    run_op(1, 37, 64'hF0F0_0F0F_1234_8001, rnd_vec(), rnd_vec(), "R4 R5");
    run_op(0, 10, '1, rnd_vec(), rnd_vec(), "R8");
    run_op(1, 100, 64'h8000_0000_0000_0001, rnd_vec(), rnd_vec(), "R8");
    iv = rnd_vec();
    run_op(0, 64, '0, rnd_vec(), iv, "R9");
    check(dst_flat == iv, "R9", "zero mask keeps init", dst_flat[63:0], iv[63:0]);
    run_op(1, 50, '0, rnd_vec(), rnd_vec(), "R9");
    run_op(0, 0, '1, rnd_vec(), rnd_vec(), "R6");

    // R7: start held during busy with other data must be ignored
    s = rnd_vec(); iv = rnd_vec(); s2 = rnd_vec();
    start = 1; op_expand = 0; vlen = 20; mask = 64'h000A_5A5F; src_flat = s; init_flat = iv;
    @(negedge clk);
    op_expand = 1; vlen = 5; mask = '1; src_flat = s2; init_flat = s2;
    repeat (3) @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    begin
      logic [NE*DW-1:0] e;
      int k = 0;
      e = iv;
      for (int i = 0; i < 20; i++) if (mask_bit(64'h000A_5A5F, i)) begin
        e[k*DW +: DW] = s[i*DW +: DW]; k++;
      end
      check(dst_flat == e, "R7", "busy start ignored dst", dst_flat[63:0], e[63:0]);
      check(int'(count) == k, "R7", "busy start ignored count", count, k);
    end

    // back-to-back and random mixes; each run_op starts in the done cycle (R6)
    for (int t = 0; t < 40; t++) begin
      mk = {$urandom, $urandom};
      run_op(t[0], int'($urandom_range(0, 70)), mk, rnd_vec(), rnd_vec(),
             t[0] ? "R4" : "R2");
    end

    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R5", "idle after done", {busy, done}, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit mask_bit(input logic [NE-1:0] m, input int i);
    return m[i];
  endfunction
endmodule